// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small microcontroller core. When the core starts a subroutine call or acknowledges an interrupt, it pushes its current program counter. On a return or a return-from-interrupt it pops the most recent entry, and the restored value appears on `ret_pc`. Six levels are held by default. Software can neither read nor write the stored entries or the depth; they change only through these events.

The interrupt controller sees a registered `full` flag and an `irq_hold` output that follows it. While `irq_hold` is high, pending interrupts stay pending and are not acknowledged. Any acknowledge that still arrives is ignored. A call made on a full stack still pushes: the oldest entry is dropped, so the stack always keeps the most recent addresses. A return made on an empty stack leaves the stack empty and sets a sticky `underflow` flag. A call or acknowledge that coincides with a return raises `collide` for that cycle, and the pair acts as a pop followed by a push.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `irq_hold`, `underflow` and `collide` are 0.
- R2: While the stack is not empty, `ret_pc` shows the most recently pushed address that has not yet been popped. Entries come back in last-in first-out order.
- R3: A return alone on a non-empty stack removes the top entry, and the depth falls by one. `empty` goes to 1 in the cycle after the last entry is popped.
- R4: `full` goes to 1 in the cycle after the push that brings the depth to DEPTH (6 by default). It stays 0 at any smaller depth.
- R5: `irq_hold` is 1 exactly when `full` is 1.
- R6: An interrupt acknowledge with no call, arriving while `full` is 1, has no effect: the depth and every stored entry are unchanged.
- R7: A call made while the stack is full pushes the new address and drops the oldest entry. The depth stays DEPTH.
- R8: A return on an empty stack leaves the stack empty and sets `underflow`, which stays 1 until reset. `ret_pc` reads 0 while the stack is empty.
- R9: A return in the same cycle as a call or acknowledge drives `collide` to 1 in that cycle. The top entry is replaced by `push_pc`, and the depth is unchanged. If the stack was empty, the depth becomes 1 and `underflow` is set.
- R10: A return alone on a full stack clears `full` and `irq_hold` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Subroutine call: push `push_pc` |
| iack_req | input | 1 | Interrupt acknowledge: push `push_pc` unless full |
| ret_req | input | 1 | Return or return-from-interrupt: pop |
| push_pc | input | PCW | Address to save |
| ret_pc | output | PCW | Current top entry (0 when empty) |
| full | output | 1 | Registered: depth equals DEPTH |
| empty | output | 1 | Depth is zero |
| irq_hold | output | 1 | Hold off interrupt acknowledge |
| underflow | output | 1 | Sticky: a return hit an empty stack |
| collide | output | 1 | Return coincides with a push request |

## Verification
A return can fall in the same cycle as a call or an interrupt acknowledge. The bench provokes this on a half-filled stack, on an empty stack and on a full stack. It judges the result through `collide`, the replaced top entry seen on `ret_pc`, and the unchanged depth that later pops expose. Overflow and the held-off acknowledge are also driven back to back on a full stack. A behavioural queue model is compared with every output on every clock.

// File: rtl/ret_addr_stack.sv
`timescale 1ns/1ps
module ret_addr_stack #(
  parameter int DEPTH = 6,
  parameter int PCW   = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_req,
  input  logic           iack_req,
  input  logic           ret_req,
  input  logic [PCW-1:0] push_pc,
  output logic [PCW-1:0] ret_pc,
  output logic           full,
  output logic           empty,
  output logic           irq_hold,
  output logic           underflow,
  output logic           collide
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] TOPCNT = CW'(DEPTH);

  logic [PCW-1:0] mem [DEPTH];
  logic [CW-1:0]  cnt, cnt_nxt;
  logic           full_q, uf_q, do_push;

  assign do_push   = call_req | (iack_req & ~full_q);
  assign collide   = ret_req & (call_req | iack_req);
  assign empty     = (cnt == '0);
  assign full      = full_q;
  assign irq_hold  = full_q;
  assign underflow = uf_q;

  always_comb begin
    ret_pc = '0;
    for (int k = 0; k < DEPTH; k++)
      if (cnt == CW'(k + 1)) ret_pc = mem[k];
  end

  always_comb begin
    cnt_nxt = cnt;
    if (ret_req && do_push) begin
      if (cnt == '0) cnt_nxt = CW'(1);
    end else if (ret_req) begin
      if (cnt != '0) cnt_nxt = cnt - CW'(1);
    end else if (do_push) begin
      if (cnt != TOPCNT) cnt_nxt = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      full_q <= 1'b0;
      uf_q   <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      cnt    <= cnt_nxt;
      full_q <= (cnt_nxt == TOPCNT);
      if (ret_req && cnt == '0) uf_q <= 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
        if (ret_req && do_push) begin
          if ((cnt == '0 && k == 0) || (cnt != '0 && cnt == CW'(k + 1)))
            mem[k] <= push_pc;
        end else if (!ret_req && do_push) begin
          if (cnt == TOPCNT) begin
            if (k == DEPTH - 1) mem[k] <= push_pc;
            else                mem[k] <= mem[(k + 1) % DEPTH];
          end else if (cnt == CW'(k)) begin
            mem[k] <= push_pc;
          end
        end
      end
    end
  end

  // R4
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  // R6
  iack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && iack_req && !call_req && !ret_req) |=> (full && $stable(ret_pc)));

  // R7
  overflow_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && call_req && !ret_req) |=> (full && ret_pc == $past(push_pc)));

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R10
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ret_req && !call_req && !iack_req) |=> !full);

  // R2
  push_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !ret_req) |=> (!empty && ret_pc == $past(push_pc)));
endmodule

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;
  localparam int DEPTH = 6;
  localparam int PCW   = 13;

  logic clk = 0, rst_n = 0, call_req = 0, iack_req = 0, ret_req = 0;
  logic [PCW-1:0] push_pc = '0;
  logic [PCW-1:0] ret_pc;
  logic full, empty, irq_hold, underflow, collide;

  ret_addr_stack #(.DEPTH(DEPTH), .PCW(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .iack_req(iack_req),
    .ret_req(ret_req), .push_pc(push_pc), .ret_pc(ret_pc), .full(full),
    .empty(empty), .irq_hold(irq_hold), .underflow(underflow), .collide(collide));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int q[$];
  bit m_uf = 0;
  bit done = 0;
  string phase = "R1 reset";

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %0d expected %0d", tag, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    bit mf = (q.size() == DEPTH);
    chk("R3 empty", int'(empty), int'(q.size() == 0));
    chk("R4 full", int'(full), int'(mf));
    chk("R5 irq_hold", int'(irq_hold), int'(mf));
    chk("R8 underflow", int'(underflow), int'(m_uf));
    chk("R9 collide", int'(collide), int'(ret_req & (call_req | iack_req)));
    chk("R2 ret_pc", int'(ret_pc), (q.size() == 0) ? 0 : q[$]);
  endtask

  task automatic step(bit c, bit i, bit r, int pc);
    bit mf, push;
    call_req = c; iack_req = i; ret_req = r; push_pc = PCW'(pc);
    #1;
    compare_all();
    mf = (q.size() == DEPTH);
    push = c | (i & !mf);
    if (r && push) begin
      if (q.size() == 0) begin m_uf = 1; q.push_back(pc); end
      else q[q.size()-1] = pc;
    end else if (r) begin
      if (q.size() == 0) m_uf = 1; else void'(q.pop_back());
    end else if (push) begin
      if (mf) void'(q.pop_front());
      q.push_back(pc);
    end
    @(posedge clk);
    @(negedge clk);
    call_req = 0; iack_req = 0; ret_req = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1 reset"; compare_all();
    phase = "R2 lifo";
    step(1,0,0,'h101); step(1,0,0,'h0A2); step(0,1,0,'h1F3);
    phase = "R3 pop";
    step(0,0,1,0); step(0,0,1,0); step(0,0,1,0); step(0,0,0,0);
    phase = "R8 empty pop";
    step(0,0,1,0); step(0,0,0,0);
    phase = "R4 fill";
    for (int k = 0; k < DEPTH; k++) step(1,0,0, 'h200 + k);
    step(0,0,0,0);
    phase = "R6 iack held";
    step(0,1,0,'h777); step(0,1,0,'h778);
    chk("R6 top unchanged", int'(ret_pc), 'h205);
    phase = "R7 overflow";
    step(1,0,0,'h300); step(1,0,0,'h301);
    phase = "R9 collide full";
    step(1,0,1,'h3AA);
    phase = "R10 pop full";
    step(0,0,1,0); step(0,0,0,0);
    chk("R10 full cleared", int'(full), 0);
    phase = "R7 drain order";
    for (int k = 0; k < DEPTH; k++) step(0,0,1,0);
    phase = "R9 collide empty";
    step(0,1,1,'h0BB); step(0,0,0,0);
    phase = "R9 collide mid";
    step(1,0,0,'h0CC); step(1,0,1,'h0DD); step(0,0,1,0); step(0,0,1,0);
    step(0,0,1,0); step(0,0,0,0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule